// File: doc/BRIEF.md
# Flash Read Page Holding Buffer

This block is a one-entry read cache between a single AHB-style read port and one bank of a flash array that does no prefetching. A read that misses the entry starts an array read. The 128-bit page that comes back is handed to the bus at once, and the page is also stored together with its address tag and error flags. Later reads into the same page are served from the entry with no wait states.

The array is a simple request/acknowledge target. The block asks for a page by its tag, and the array answers with one acknowledge cycle that carries the page data and three flags: transfer error, uncorrectable multi-bit ECC, and corrected single-bit ECC.

The stored page is invalidated in three ways:
- a falling edge on the flash-operation-done input;
- a non-sequential access whose upper address bits are non-zero, which is used to emulate wait states;
- clearing the software enable input.

Top module: `fpage_hold_buf`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted access, the outputs are hreadyout=1, hresp=0, fl_req=0 and ecc_alert=0, and the entry is invalid.
- R2: An access is accepted in a cycle where htrans is NONSEQ (2'b10) or SEQ (2'b11) and hreadyout=1. For an accepted access that misses, fl_req rises in the next cycle with fl_page=haddr[23:4]. fl_req and fl_page hold and hreadyout stays 0 until fl_ack. In the error-free acknowledge cycle, hreadyout=1 and hrdata is 32-bit word haddr[3:2] of fl_rdata, where word 0 is bits 31:0.
- R3: An accepted access hits when the entry is valid, sw_buf_en=1 and haddr[23:4] equals the stored tag. A hit completes in the next cycle with hreadyout=1, hresp=0, no fl_req, and hrdata set to word haddr[3:2] of the stored page.
- R4: An acknowledge with fl_xfr_err or fl_mbe set is followed by a two-cycle error response: first hresp=1 with hreadyout=0, then hresp=1 with hreadyout=1. The entry is left unchanged.
- R5: A page acknowledged with only fl_sbe set is stored and marked valid. ecc_alert is 1 for exactly the completing cycle of that miss and of every later hit on that page.
- R6: A 1-to-0 transition of fl_done invalidates the entry.
- R7: An accepted NONSEQ access with a non-zero haddr[28:24] invalidates the entry and is itself a miss. A SEQ access with non-zero haddr[28:24] does not invalidate.
- R8: While sw_buf_en=0 the entry is held invalid and no hits are served. After sw_buf_en returns to 1, the entry stays invalid until the next fill.
- R9: When an invalidation and a fill fall in the same cycle, the entry ends invalid.
- R10: htrans IDLE (2'b00) and BUSY (2'b01) are ignored. They start no array read, keep hreadyout=1 and leave the entry unchanged.
- R11: An access accepted in the cycle in which a fill completes is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_buf_en | input | 1 | Software buffer enable |
| fl_done | input | 1 | Flash operation done; a falling edge invalidates |
| htrans | input | 2 | Transfer type |
| haddr | input | 32 | Byte address |
| hreadyout | output | 1 | Transfer complete |
| hresp | output | 1 | Error response |
| hrdata | output | 32 | Read data |
| ecc_alert | output | 1 | One-cycle corrected-ECC notice |
| fl_req | output | 1 | Array read request |
| fl_page | output | 20 | Requested page tag (address bits 23:4) |
| fl_ack | input | 1 | Array read acknowledge |
| fl_rdata | input | 128 | Array page data, valid with fl_ack |
| fl_xfr_err | input | 1 | Array transfer error, valid with fl_ack |
| fl_mbe | input | 1 | Array multi-bit ECC error, valid with fl_ack |
| fl_sbe | input | 1 | Array corrected single-bit ECC, valid with fl_ack |

## Verification
Each result is due at a fixed point:
- A hit is due one cycle after its address is accepted.
- A miss completes in the cycle fl_ack is seen.
- The error response occupies the two cycles after an erroring acknowledge.
- An invalidation first shows on the next accepted address.

The bench steps one cycle at a time. It drives inputs on the falling edge and compares every output 1 ns later against its own model, which advances on the rising edge. Every result is therefore checked in exactly the cycle it is due. Counts of array reads, alert cycles and error cycles per scenario confirm each hit-or-miss outcome.

// File: rtl/fphb_pkg.sv
package fphb_pkg;
  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_BUSY   = 2'b01;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HIT  = 3'd1,
    ST_MISS = 3'd2,
    ST_ERR1 = 3'd3,
    ST_ERR2 = 3'd4
  } fphb_state_e;

  typedef struct packed {
    logic xfr;
    logic mbe;
    logic sbe;
  } fphb_flags_t;
endpackage

// File: rtl/fphb_rst_sync.sv
module fphb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fphb_entry.sv
module fphb_entry
  import fphb_pkg::*;
#(
  parameter int TAG_W  = 20,
  parameter int PAGE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              inval,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PAGE_W-1:0] fill_page,
  input  fphb_flags_t       fill_flags,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [PAGE_W-1:0] page,
  output fphb_flags_t       flags
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [PAGE_W-1:0] page_q, page_d;
  fphb_flags_t       flags_q, flags_d;

  // invalidation has priority over a fill in the same cycle
  always_comb begin
    valid_d = valid_q;
    if (inval)        valid_d = 1'b0;
    else if (fill_en) valid_d = 1'b1;
  end

  always_comb begin
    tag_d   = fill_en ? fill_tag   : tag_q;
    page_d  = fill_en ? fill_page  : page_q;
    flags_d = fill_en ? fill_flags : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // storage without reset: only read while valid_q is set
  always_ff @(posedge clk) begin
    tag_q   <= tag_d;
    page_q  <= page_d;
    flags_q <= flags_d;
  end

  assign valid = valid_q;
  assign tag   = tag_q;
  assign page  = page_q;
  assign flags = flags_q;
endmodule

// File: rtl/fphb_wsel.sv
module fphb_wsel #(
  parameter int PAGE_W = 128,
  parameter int BUS_W  = 32,
  parameter int WSEL_W = 2
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [WSEL_W-1:0] sel,
  output logic [BUS_W-1:0]  word
);
  localparam int LANES = PAGE_W / BUS_W;

  logic [BUS_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = page[g*BUS_W +: BUS_W];
  end

  assign word = lane[sel];
endmodule

// File: rtl/fphb_ctrl.sv
module fphb_ctrl
  import fphb_pkg::*;
#(
  parameter int TAG_W  = 20,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        htrans,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [WSEL_W-1:0] req_wsel,
  input  logic              req_emu_nz,
  input  logic              sw_en,
  input  logic              fl_done,
  input  logic              fl_ack,
  input  logic              fl_xfr_err,
  input  logic              fl_mbe,
  input  logic              fl_sbe,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic              ent_sbe,
  output logic              hreadyout,
  output logic              hresp,
  output logic              ecc_alert,
  output logic              fl_req,
  output logic              fill_en,
  output logic              inval,
  output logic              sel_flash,
  output logic [TAG_W-1:0]  tag_q,
  output logic [WSEL_W-1:0] wsel_q,
  output fphb_state_e       state_q
);
  fphb_state_e       state_d;
  logic              done_q;
  logic [TAG_W-1:0]  tag_d;
  logic [WSEL_W-1:0] wsel_d;
  logic              fl_err, done_fall, accept, emu_inval, hit, miss_end;

  assign fl_err    = fl_xfr_err | fl_mbe;
  assign miss_end  = (state_q == ST_MISS) & fl_ack;
  assign done_fall = done_q & ~fl_done;

  always_comb begin
    if (state_q == ST_MISS) hreadyout = fl_ack & ~fl_err;
    else                    hreadyout = (state_q != ST_ERR1);
  end

  assign hresp     = (state_q == ST_ERR1) | (state_q == ST_ERR2);
  assign accept    = hreadyout & htrans[1];
  assign emu_inval = accept & (htrans == HT_NONSEQ) & req_emu_nz;
  assign inval     = done_fall | ~sw_en | emu_inval;
  assign fill_en   = miss_end & ~fl_err;
  assign hit       = accept & ent_valid & sw_en & ~inval & ~fill_en & (req_tag == ent_tag);

  assign fl_req    = (state_q == ST_MISS);
  assign sel_flash = (state_q == ST_MISS);
  assign ecc_alert = ((state_q == ST_HIT) & ent_sbe) | (fill_en & fl_sbe);

  always_comb begin
    state_d = state_q;
    if (miss_end && fl_err)      state_d = ST_ERR1;
    else if (state_q == ST_ERR1) state_d = ST_ERR2;
    else if (hreadyout)          state_d = accept ? (hit ? ST_HIT : ST_MISS) : ST_IDLE;
  end

  always_comb begin
    tag_d  = accept ? req_tag  : tag_q;
    wsel_d = accept ? req_wsel : wsel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fl_done;
    end
  end

  always_ff @(posedge clk) begin
    tag_q  <= tag_d;
    wsel_q <= wsel_d;
  end
endmodule

// File: rtl/fpage_hold_buf.sv
module fpage_hold_buf
  import fphb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 128,
  parameter int BUS_W  = 32,
  parameter int TAG_HI = 23,
  parameter int EMU_HI = 28,
  localparam int TAG_LO  = $clog2(PAGE_W / 8),
  localparam int TAG_W   = TAG_HI - TAG_LO + 1,
  localparam int WORD_LO = $clog2(BUS_W / 8),
  localparam int WSEL_W  = $clog2(PAGE_W / BUS_W),
  localparam int EMU_LO  = TAG_HI + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_buf_en,
  input  logic              fl_done,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  output logic              hreadyout,
  output logic              hresp,
  output logic [BUS_W-1:0]  hrdata,
  output logic              ecc_alert,
  output logic              fl_req,
  output logic [TAG_W-1:0]  fl_page,
  input  logic              fl_ack,
  input  logic [PAGE_W-1:0] fl_rdata,
  input  logic              fl_xfr_err,
  input  logic              fl_mbe,
  input  logic              fl_sbe
);
  logic              rst_sync_n;
  logic              fill_en, inval, sel_flash, ent_valid;
  logic [TAG_W-1:0]  ent_tag, tag_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [PAGE_W-1:0] ent_page, src_page;
  fphb_flags_t       ent_flags, fill_flags;
  fphb_state_e       state_q;
  logic              unused_bits;

  assign unused_bits = ^{haddr[ADDR_W-1:EMU_HI+1], haddr[WORD_LO-1:0],
                         ent_flags.xfr, ent_flags.mbe};

  fphb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fphb_ctrl #(.TAG_W(TAG_W), .WSEL_W(WSEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .htrans     (htrans),
    .req_tag    (haddr[TAG_HI:TAG_LO]),
    .req_wsel   (haddr[TAG_LO-1:WORD_LO]),
    .req_emu_nz (|haddr[EMU_HI:EMU_LO]),
    .sw_en      (sw_buf_en),
    .fl_done    (fl_done),
    .fl_ack     (fl_ack),
    .fl_xfr_err (fl_xfr_err),
    .fl_mbe     (fl_mbe),
    .fl_sbe     (fl_sbe),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_sbe    (ent_flags.sbe),
    .hreadyout  (hreadyout),
    .hresp      (hresp),
    .ecc_alert  (ecc_alert),
    .fl_req     (fl_req),
    .fill_en    (fill_en),
    .inval      (inval),
    .sel_flash  (sel_flash),
    .tag_q      (tag_q),
    .wsel_q     (wsel_q),
    .state_q    (state_q)
  );

  assign fill_flags = '{xfr: fl_xfr_err, mbe: fl_mbe, sbe: fl_sbe};

  fphb_entry #(.TAG_W(TAG_W), .PAGE_W(PAGE_W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fill_en    (fill_en),
    .inval      (inval),
    .fill_tag   (tag_q),
    .fill_page  (fl_rdata),
    .fill_flags (fill_flags),
    .valid      (ent_valid),
    .tag        (ent_tag),
    .page       (ent_page),
    .flags      (ent_flags)
  );

  // miss data bypasses the entry straight to the bus
  assign src_page = sel_flash ? fl_rdata : ent_page;

  fphb_wsel #(.PAGE_W(PAGE_W), .BUS_W(BUS_W), .WSEL_W(WSEL_W)) u_wsel (
    .page (src_page),
    .sel  (wsel_q),
    .word (hrdata)
  );

  assign fl_page = tag_q;
endmodule

// File: rtl/fphb_chk.sv
module fphb_chk
  import fphb_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hreadyout,
  input logic             hresp,
  input logic             ecc_alert,
  input logic             fl_req,
  input logic             fl_ack,
  input logic [TAG_W-1:0] fl_page,
  input logic [1:0]       htrans,
  input logic             emu_nz,
  input logic             sw_buf_en,
  input logic             fl_done,
  input logic             ent_valid,
  input fphb_state_e      state_q
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (hreadyout && !hresp && !fl_req && !ecc_alert && !ent_valid));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_page)));

  p_miss_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |-> !hreadyout);

  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIT) |-> (!fl_req && !hresp));

  p_err_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  p_alert_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_alert |-> (hreadyout && !hresp));

  p_done_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_done) |-> ##1 !ent_valid);

  p_emu_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hreadyout && htrans == HT_NONSEQ && emu_nz) |=> !ent_valid);

  p_sw_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_buf_en |=> !ent_valid);

  p_idle_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hreadyout && !htrans[1]) |=> (!fl_req && !hresp));
endmodule

bind fpage_hold_buf fphb_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hreadyout (hreadyout),
  .hresp     (hresp),
  .ecc_alert (ecc_alert),
  .fl_req    (fl_req),
  .fl_ack    (fl_ack),
  .fl_page   (fl_page),
  .htrans    (htrans),
  .emu_nz    (|haddr[EMU_HI:EMU_LO]),
  .sw_buf_en (sw_buf_en),
  .fl_done   (fl_done),
  .ent_valid (ent_valid),
  .state_q   (state_q)
);

// File: tb/fpage_hold_buf_test.sv
module fpage_hold_buf_test;
  import fphb_pkg::*;

  localparam int HALF = 10;
  localparam int LAT  = 3;
  localparam logic [19:0] T_SBE = 20'h00020;
  localparam logic [19:0] T_XFR = 20'h00030;
  localparam logic [19:0] T_MBE = 20'h00040;

  logic clk = 1'b0;
  always #HALF clk = ~clk;

  logic         rst_n, sw_buf_en, fl_done, fl_ack, fl_xfr_err, fl_mbe, fl_sbe;
  logic [1:0]   htrans;
  logic [31:0]  haddr;
  logic [127:0] fl_rdata;
  logic         hreadyout, hresp, ecc_alert, fl_req;
  logic [31:0]  hrdata;
  logic [19:0]  fl_page;

  fpage_hold_buf uut (
    .clk(clk), .rst_n(rst_n), .sw_buf_en(sw_buf_en), .fl_done(fl_done),
    .htrans(htrans), .haddr(haddr), .hreadyout(hreadyout), .hresp(hresp),
    .hrdata(hrdata), .ecc_alert(ecc_alert), .fl_req(fl_req), .fl_page(fl_page),
    .fl_ack(fl_ack), .fl_rdata(fl_rdata), .fl_xfr_err(fl_xfr_err),
    .fl_mbe(fl_mbe), .fl_sbe(fl_sbe)
  );

  // stimulus applied at the next falling edge
  logic [1:0]  p_tr;
  logic [31:0] p_addr;
  logic        p_en, p_done, fall_on_ack;
  int          fcnt;

  // reference model state
  int           m_st;
  logic         m_valid, m_sbe, m_done_q, m_acc;
  logic [19:0]  m_tag, m_ptag;
  logic [1:0]   m_wsel;
  logic [127:0] m_page;

  int    n_cmp = 0, n_mis = 0, n_req = 0, n_alert = 0, n_resp = 0;
  string cur_tag = "R1";

  function automatic logic [127:0] mkpage(input logic [19:0] t);
    logic [127:0] p;
    for (int i = 0; i < 4; i++)
      p[i*32 +: 32] = (32'(t) * 32'h9E37_79B1) ^ (32'h1111_1111 * 32'(i + 1));
    return p;
  endfunction

  function automatic logic [31:0] wd(input logic [127:0] p, input logic [1:0] s);
    return p[32*s +: 32];
  endfunction

  task automatic chk(input string tg, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic step();
    logic err, e_rdy, e_resp, e_req, e_alert, fall, acc, inv, fill, hit;
    @(negedge clk);
    htrans = p_tr; haddr = p_addr; sw_buf_en = p_en; fl_done = p_done;
    if (fl_ack) begin
      fl_ack = 1'b0; fl_xfr_err = 1'b0; fl_mbe = 1'b0; fl_sbe = 1'b0; fcnt = 0;
    end else if (fl_req) begin
      fcnt++;
      if (fcnt >= LAT) begin
        fl_ack = 1'b1; n_req++;
        fl_rdata   = mkpage(fl_page);
        fl_xfr_err = (fl_page == T_XFR);
        fl_mbe     = (fl_page == T_MBE);
        fl_sbe     = (fl_page == T_SBE);
        if (fall_on_ack) begin fl_done = 1'b0; p_done = 1'b0; fall_on_ack = 1'b0; end
      end
    end
    #1;
    err     = fl_xfr_err | fl_mbe;
    e_rdy   = (m_st == 2) ? (fl_ack && !err) : (m_st != 3);
    e_resp  = (m_st == 3) || (m_st == 4);
    e_req   = (m_st == 2);
    e_alert = (m_st == 1 && m_sbe) || (m_st == 2 && fl_ack && !err && fl_sbe);
    chk(cur_tag, "hreadyout", 128'(hreadyout), 128'(e_rdy));
    chk(cur_tag, "hresp", 128'(hresp), 128'(e_resp));
    chk(cur_tag, "fl_req", 128'(fl_req), 128'(e_req));
    chk(cur_tag, "ecc_alert", 128'(ecc_alert), 128'(e_alert));
    if (e_rdy && m_st == 1) chk(cur_tag, "hrdata hit", 128'(hrdata), 128'(wd(m_page, m_wsel)));
    if (e_rdy && m_st == 2) chk(cur_tag, "hrdata bypass", 128'(hrdata), 128'(wd(fl_rdata, m_wsel)));
    if (e_req) chk(cur_tag, "fl_page", 128'(fl_page), 128'(m_ptag));
    if (ecc_alert) n_alert++;
    if (hresp) n_resp++;
    @(posedge clk);
    if (!rst_n) begin
      m_st = 0; m_valid = 1'b0; m_done_q = 1'b0; m_acc = 1'b0;
    end else begin
      fall = m_done_q && !fl_done;
      acc  = e_rdy && htrans[1];
      inv  = fall || !sw_buf_en || (acc && htrans == HT_NONSEQ && haddr[28:24] != 5'd0);
      fill = (m_st == 2) && fl_ack && !err;
      hit  = acc && m_valid && sw_buf_en && !inv && !fill && (haddr[23:4] == m_tag);
      if (fill) begin m_tag = m_ptag; m_page = fl_rdata; m_sbe = fl_sbe; end
      if (inv) m_valid = 1'b0; else if (fill) m_valid = 1'b1;
      if (m_st == 2 && fl_ack && err) m_st = 3;
      else if (m_st == 3) m_st = 4;
      else if (e_rdy) m_st = acc ? (hit ? 1 : 2) : 0;
      if (acc) begin m_ptag = haddr[23:4]; m_wsel = haddr[3:2]; end
      m_done_q = fl_done;
      m_acc = acc;
    end
  endtask

  task automatic rd(input logic [1:0] tr, input logic [31:0] a);
    p_tr = tr; p_addr = a;
    do step(); while (!m_acc);
    p_tr = HT_IDLE;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_mis++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b1; p_tr = HT_IDLE; p_addr = '0; p_en = 1'b1; p_done = 1'b0;
    fall_on_ack = 1'b0; fcnt = 0;
    htrans = HT_IDLE; haddr = '0; sw_buf_en = 1'b1; fl_done = 1'b0;
    fl_ack = 1'b0; fl_rdata = '0; fl_xfr_err = 1'b0; fl_mbe = 1'b0; fl_sbe = 1'b0;
    m_st = 0; m_valid = 1'b0; m_done_q = 1'b0; m_acc = 1'b0; m_sbe = 1'b0;
    m_tag = '0; m_ptag = '0; m_wsel = '0; m_page = '0;
    #1 rst_n = 1'b0;
    idle(3);
    chk("R1", "hreadyout in reset", 128'(hreadyout), 128'(1'b1));
    chk("R1", "fl_req in reset", 128'(fl_req), 128'(1'b0));
    rst_n = 1'b1;
    idle(4);

    // R2: miss with bypass data
    cur_tag = "R2"; b = n_req;
    rd(HT_NONSEQ, 32'h0000_0104); idle(6);
    chk("R2", "array reads", 128'(n_req - b), 128'(1));

    // R3: hits back to back
    cur_tag = "R3"; b = n_req;
    rd(HT_SEQ, 32'h0000_0108); rd(HT_SEQ, 32'h0000_010C); rd(HT_NONSEQ, 32'h0000_0100); idle(3);
    chk("R3", "array reads", 128'(n_req - b), 128'(0));

    // R5: corrected ECC page stored, alert on miss and hit
    cur_tag = "R5"; b = n_alert;
    rd(HT_NONSEQ, 32'h0000_0204); idle(6); rd(HT_NONSEQ, 32'h0000_0208); idle(2);
    chk("R5", "alert cycles", 128'(n_alert - b), 128'(2));

    // R4: error responses, entry kept
    cur_tag = "R4"; b = n_req; n_resp = 0;
    rd(HT_NONSEQ, 32'h0000_0304); idle(6);
    rd(HT_NONSEQ, 32'h0000_0200); idle(2);
    rd(HT_NONSEQ, 32'h0000_0300); idle(6);
    rd(HT_NONSEQ, 32'h0000_0400); idle(6);
    rd(HT_NONSEQ, 32'h0000_0204); idle(2);
    chk("R4", "array reads", 128'(n_req - b), 128'(3));
    chk("R4", "error cycles", 128'(n_resp), 128'(6));

    // R6: done falling edge
    cur_tag = "R6"; b = n_req;
    p_done = 1'b1; idle(2); p_done = 1'b0; idle(2);
    rd(HT_NONSEQ, 32'h0000_0200); idle(6);
    chk("R6", "array reads", 128'(n_req - b), 128'(1));

    // R7: emulation bits on NONSEQ only
    cur_tag = "R7"; b = n_req;
    rd(HT_SEQ, 32'h0100_0204); rd(HT_NONSEQ, 32'h0100_0208); idle(6);
    rd(HT_NONSEQ, 32'h0000_020C); idle(2);
    chk("R7", "array reads", 128'(n_req - b), 128'(1));

    // R8: software enable
    cur_tag = "R8"; b = n_req;
    p_en = 1'b0; idle(1);
    rd(HT_NONSEQ, 32'h0000_0200); idle(6);
    p_en = 1'b1;
    rd(HT_NONSEQ, 32'h0000_0204); idle(6);
    rd(HT_NONSEQ, 32'h0000_0208); idle(2);
    chk("R8", "array reads", 128'(n_req - b), 128'(2));

    // R9: done falls in the fill cycle
    cur_tag = "R9"; b = n_req;
    p_done = 1'b1; idle(2); fall_on_ack = 1'b1;
    rd(HT_NONSEQ, 32'h0000_0104); idle(6);
    rd(HT_NONSEQ, 32'h0000_0108); idle(6);
    chk("R9", "array reads", 128'(n_req - b), 128'(2));

    // R11: access accepted in a fill cycle misses
    cur_tag = "R11"; b = n_req;
    rd(HT_NONSEQ, 32'h0000_0204); rd(HT_NONSEQ, 32'h0000_0108); idle(6);
    rd(HT_NONSEQ, 32'h0000_010C); idle(2);
    chk("R11", "array reads", 128'(n_req - b), 128'(2));

    // R10: IDLE and BUSY ignored
    cur_tag = "R10"; b = n_req;
    p_tr = HT_BUSY; p_addr = 32'h1F00_0204; idle(4);
    p_tr = HT_IDLE; idle(2);
    rd(HT_SEQ, 32'h0000_0100); idle(2);
    chk("R10", "array reads", 128'(n_req - b), 128'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule